// File: doc/BRIEF.md
# Link Status Word Generator

This block assembles the read-only 16-bit link status word for one port of a serial point-to-point link. It merges the current line rate, the lane count the link settled on, whether the data-link layer is up, and a flag showing that link training is under way. It also keeps one piece of state, the common reference clock bit, which starts from a strapping pin chosen by the port's role and can later be replaced by a value from the non-volatile configuration loader.

The lane-count field is not a simple copy of the negotiated width. If the configured maximum width is a value this port cannot support, the field echoes that configured value. If the configured value is supported but the link has not trained, the field reads zero. The training flag follows the training state machine while it is in its configuration or recovery states. A retrain request sets the flag straight away and holds it until training begins. The block also sends a one-cycle kick to the training state machine. On a downstream port the kick follows the request at once. On an upstream port it waits a parameterised number of cycles, which stands for the 1 ms delay, and a new request restarts that wait.

Top module: `lnksts_reg`

## Requirements
- R1: Bits 3:0 read 1 when `rate_gen2` is 0 and 2 when `rate_gen2` is 1.
- R2: Training states are coded on `ltssm_state` as 0 detect, 1 polling, 2 configuration, 3 active, 4 recovery, 5 low power, 6 disabled and 7 hot reset. The link counts as trained in states 3, 4 and 5. The port supports a width code when that code is one of 1, 2, 4, 8, 12, 16 or 32 and is no greater than `PORT_LANES`. When `cap_max_width` holds a supported code and the link is trained, bits 9:4 equal `neg_lanes` if it is one of those seven codes, and 0 otherwise.
- R3: When `cap_max_width` is not a supported code, bits 9:4 equal `cap_max_width`, whatever the training state or negotiated width.
- R4: When `cap_max_width` is a supported code and the link is not trained (states 0, 1, 2, 6, 7), bits 9:4 read 0.
- R5: Bit 11 reads 1 whenever `ltssm_state` is 2 or 4, and it drops as soon as the state leaves those two codes, unless a retrain is pending.
- R6: A retrain request sampled on a clock edge sets bit 11 from that edge onward. The bit stays set until an edge at which the state is 2 or 4 and no upstream delay is running.
- R7: A downstream port (`is_upstream`=0) pulses `train_kick` for one cycle, in the cycle after the request edge. An upstream port pulses it `RETRAIN_DLY` cycles later than that. A further request during the wait restarts the count from that request.
- R8: On reset, bit 12 takes `strap_cclk_us` if `is_upstream` is 1 and `strap_cclk_ds` otherwise. Strap changes after reset have no effect.
- R9: A cycle with `nv_cclk_load` high loads `nv_cclk_val` into bit 12 from the next cycle onward.
- R10: Bit 13 equals `dll_active` when `cap_dll_rep` is 1, and it is 0 whenever `cap_dll_rep` is 0.
- R11: Bits 10, 14 and 15 always read 0.
- R12: Reset is synchronous and active low. It clears the pending retrain, the delay counter and `train_kick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ltssm_state | input | 3 | Current training state code |
| rate_gen2 | input | 1 | 1 = second-generation rate |
| neg_lanes | input | 6 | Negotiated lane count |
| cap_max_width | input | 6 | Configured maximum width code |
| cap_dll_rep | input | 1 | Link-active reporting capability |
| dll_active | input | 1 | Data-link layer active |
| retrain_req | input | 1 | Retrain request strobe |
| is_upstream | input | 1 | Port role, 1 = upstream |
| strap_cclk_us | input | 1 | Common-clock strap, upstream role |
| strap_cclk_ds | input | 1 | Common-clock strap, downstream role |
| nv_cclk_load | input | 1 | Non-volatile override strobe |
| nv_cclk_val | input | 1 | Non-volatile override value |
| train_kick | output | 1 | Retrain command pulse to the training state machine |
| link_status | output | 16 | Assembled status word |

## Verification
The assertions assume that `is_upstream` changes only while reset is held, and that `RETRAIN_DLY` is at least 1. They also assume the retrain request is a strobe, so the restart rule applies only to repeated pulses. The stimulus changes role only inside reset sequences and drives every request as a single-cycle pulse. It then sweeps every combination of training state, configured width and negotiated width, and times the kick against an arithmetic count of edges from the request.

// File: rtl/lnksts_pkg.sv
// Package: shared codes for the link status word generator.
// Assumes: training state arrives as a 3-bit code; width codes are lane counts.
package lnksts_pkg;

    typedef enum logic [2:0] {
        ST_DETECT   = 3'd0,
        ST_POLLING  = 3'd1,
        ST_CONFIG   = 3'd2,
        ST_ACTIVE   = 3'd3,
        ST_RECOVERY = 3'd4,
        ST_LOWPWR   = 3'd5,
        ST_DISABLED = 3'd6,
        ST_HOTRST   = 3'd7
    } train_st_e;

    localparam logic [3:0] SPD_GEN1 = 4'd1;
    localparam logic [3:0] SPD_GEN2 = 4'd2;

    // True when the code is one of the defined width encodings.
    function automatic logic width_code_ok(input logic [5:0] code);
        return (code == 6'd1)  || (code == 6'd2)  || (code == 6'd4) ||
               (code == 6'd8)  || (code == 6'd12) || (code == 6'd16) ||
               (code == 6'd32);
    endfunction

    // True while the training state machine is configuring or recovering.
    function automatic logic st_is_training(input train_st_e st);
        return (st == ST_CONFIG) || (st == ST_RECOVERY);
    endfunction

    // True when the link has trained (active, recovery, low power).
    function automatic logic st_is_trained(input train_st_e st);
        return (st == ST_ACTIVE) || (st == ST_RECOVERY) || (st == ST_LOWPWR);
    endfunction

endpackage

// File: rtl/lnksts_width_sel.sv
// Module: lnksts_width_sel
// Resolves the reported width field from the configured maximum width,
// the negotiated lane count and the training state.
// Assumes: PORT_LANES is the widest lane count the port can form.
module lnksts_width_sel
    import lnksts_pkg::*;
#(
    parameter int PORT_LANES = 4,
    parameter int WW         = 6
) (
    input  train_st_e         st,
    input  logic [WW-1:0]     cap_w,
    input  logic [WW-1:0]     neg_w,
    output logic [WW-1:0]     width_fld
);
    localparam int LANE_LIM = PORT_LANES;

    logic cap_supported;
    logic neg_legal;

    // Classify the configured and negotiated codes.
    always_comb begin
        cap_supported = width_code_ok(cap_w) && (int'(cap_w) <= LANE_LIM);
        neg_legal     = width_code_ok(neg_w);
    end

    // Choose echo of configuration, zero when untrained, else negotiated.
    always_comb begin
        if (!cap_supported)
            width_fld = cap_w;
        else if (!st_is_trained(st))
            width_fld = '0;
        else if (neg_legal)
            width_fld = neg_w;
        else
            width_fld = '0;
    end

endmodule

// File: rtl/lnksts_retrain_trk.sv
// Module: lnksts_retrain_trk
// Tracks a pending retrain request and issues the retrain kick, at once on
// a downstream port or after DLY cycles on an upstream port.
// Assumes: up_role is static outside reset; req is a strobe; DLY >= 1.
module lnksts_retrain_trk #(
    parameter int DLY = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic up_role,
    input  logic in_training,
    output logic pending,
    output logic kick
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(DLY);
    localparam logic [CW-1:0] CNT_LAST = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          busy;

    assign busy = (cnt_q != '0);

    // Delay counter: load on upstream request, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (req && up_role)
            cnt_q <= CNT_LOAD;
        else if (busy)
            cnt_q <= cnt_q - CNT_LAST;
    end

    // Kick pulse: downstream follows request, upstream follows expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            kick <= 1'b0;
        else
            kick <= (req && !up_role) || (!req && up_role && (cnt_q == CNT_LAST));
    end

    // Pending flag: set by request, released once training has begun.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (req)
            pending <= 1'b1;
        else if (in_training && !busy)
            pending <= 1'b0;
    end

    // R6: pending is held while training has not started.
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !in_training && !req) |=> pending);

    // R7: upstream request never kicks on the next cycle.
    p_up_no_early_kick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && up_role) |=> !kick);

    // R7: downstream request kicks on the next cycle.
    p_ds_kick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !up_role) |=> kick);

    // R7: kick is a single-cycle pulse for a single request.
    p_kick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !req) |=> !kick);

endmodule

// File: rtl/lnksts_clkcfg.sv
// Module: lnksts_clkcfg
// Holds the common reference clock bit: loaded from the role's strap on
// reset, replaceable by a non-volatile configuration value.
// Assumes: up_role is static outside reset.
module lnksts_clkcfg (
    input  logic clk,
    input  logic rst_n,
    input  logic up_role,
    input  logic strap_us,
    input  logic strap_ds,
    input  logic nv_load,
    input  logic nv_val,
    output logic cclk_bit
);
    // Common clock bit: strap on reset, override on load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cclk_bit <= up_role ? strap_us : strap_ds;
        else if (nv_load)
            cclk_bit <= nv_val;
    end

    // R8: without an override the bit does not move.
    p_cclk_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !nv_load |=> $stable(cclk_bit));

    // R9: an override lands on the following cycle.
    p_nv_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nv_load |=> (cclk_bit == $past(nv_val)));

endmodule

// File: rtl/lnksts_reg.sv
// Module: lnksts_reg (top)
// Assembles the 16-bit link status word for one port and drives the
// retrain kick toward the training state machine.
// Assumes: is_upstream changes only in reset; RETRAIN_DLY >= 1.
module lnksts_reg
    import lnksts_pkg::*;
#(
    parameter int PORT_LANES  = 4,
    parameter int RETRAIN_DLY = 125000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  ltssm_state,
    input  logic        rate_gen2,
    input  logic [5:0]  neg_lanes,
    input  logic [5:0]  cap_max_width,
    input  logic        cap_dll_rep,
    input  logic        dll_active,
    input  logic        retrain_req,
    input  logic        is_upstream,
    input  logic        strap_cclk_us,
    input  logic        strap_cclk_ds,
    input  logic        nv_cclk_load,
    input  logic        nv_cclk_val,
    output logic        train_kick,
    output logic [15:0] link_status
);
    localparam int WW = 6;

    train_st_e      st;
    logic [WW-1:0]  width_fld;
    logic           in_train;
    logic           pend;
    logic           cclk_bit;
    logic [3:0]     spd_fld;

    assign st       = train_st_e'(ltssm_state);
    assign in_train = st_is_training(st);

    lnksts_width_sel #(
        .PORT_LANES (PORT_LANES),
        .WW         (WW)
    ) u_width (
        .st        (st),
        .cap_w     (cap_max_width),
        .neg_w     (neg_lanes),
        .width_fld (width_fld)
    );

    lnksts_retrain_trk #(
        .DLY (RETRAIN_DLY)
    ) u_retrain (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (retrain_req),
        .up_role     (is_upstream),
        .in_training (in_train),
        .pending     (pend),
        .kick        (train_kick)
    );

    lnksts_clkcfg u_cclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_role  (is_upstream),
        .strap_us (strap_cclk_us),
        .strap_ds (strap_cclk_ds),
        .nv_load  (nv_cclk_load),
        .nv_val   (nv_cclk_val),
        .cclk_bit (cclk_bit)
    );

    // Speed field from the current rate.
    assign spd_fld = rate_gen2 ? SPD_GEN2 : SPD_GEN1;

    // Pack the status word; reserved and error bits read zero.
    always_comb begin
        link_status        = '0;
        link_status[3:0]   = spd_fld;
        link_status[9:4]   = width_fld;
        link_status[10]    = 1'b0;
        link_status[11]    = in_train || pend;
        link_status[12]    = cclk_bit;
        link_status[13]    = dll_active && cap_dll_rep;
    end

    // R10: link-active bit gated by the reporting capability.
    p_dll_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_dll_rep |-> !link_status[13]);

    // R4: untrained link with supported configuration reports zero width.
    p_untrained_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ltssm_state inside {3'd0, 3'd1} && width_code_ok(cap_max_width)
         && int'(cap_max_width) <= PORT_LANES) |-> (link_status[9:4] == '0));

    // R6: a request shows training in progress on the next cycle.
    p_req_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        retrain_req |=> link_status[11]);

    // R11: reserved bits stay zero.
    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (link_status[15:14] == 2'b00) && !link_status[10]);

endmodule

// File: tb/lnksts_reg_test.sv
module lnksts_reg_test;
    localparam int CLK_P = 10;
    localparam int LANES = 4;
    localparam int DLY   = 6;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  ltssm_state = 3'd3;
    logic        rate_gen2 = 0;
    logic [5:0]  neg_lanes = 6'd1;
    logic [5:0]  cap_max_width = 6'd4;
    logic        cap_dll_rep = 0;
    logic        dll_active = 0;
    logic        retrain_req = 0;
    logic        is_upstream = 0;
    logic        strap_cclk_us = 0;
    logic        strap_cclk_ds = 0;
    logic        nv_cclk_load = 0;
    logic        nv_cclk_val = 0;
    logic        train_kick;
    logic [15:0] link_status;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    lnksts_reg #(.PORT_LANES(LANES), .RETRAIN_DLY(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .ltssm_state(ltssm_state),
        .rate_gen2(rate_gen2), .neg_lanes(neg_lanes),
        .cap_max_width(cap_max_width), .cap_dll_rep(cap_dll_rep),
        .dll_active(dll_active), .retrain_req(retrain_req),
        .is_upstream(is_upstream), .strap_cclk_us(strap_cclk_us),
        .strap_cclk_ds(strap_cclk_ds), .nv_cclk_load(nv_cclk_load),
        .nv_cclk_val(nv_cclk_val), .train_kick(train_kick),
        .link_status(link_status)
    );

    task automatic check(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic up);
        rst_n = 0;
        is_upstream = up;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic pulse_req();
        retrain_req = 1;
        tick();
        retrain_req = 0;
    endtask

    function automatic bit legal(input int v);
        return v == 1 || v == 2 || v == 4 || v == 8 || v == 12 || v == 16 || v == 32;
    endfunction

    function automatic int exp_width(input int st, input int cap, input int neg);
        bit trained = (st == 3) || (st == 4) || (st == 5);
        if (!(legal(cap) && cap <= LANES)) return cap;
        if (!trained) return 0;
        return legal(neg) ? neg : 0;
    endfunction

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            done = 1;
        end
        $finish;
    end

    initial begin
        // R8 / R12: reset state with upstream role
        strap_cclk_us = 1; strap_cclk_ds = 0;
        do_reset(1'b1);
        ltssm_state = 3'd3;
        #1;
        check("R12 kick after reset", train_kick, 0);
        check("R12 bit11 after reset", link_status[11], 0);
        check("R8 strap upstream", link_status[12], 1);
        strap_cclk_us = 0;
        tick(); tick();
        check("R8 strap change ignored", link_status[12], 1);
        // R9 override
        nv_cclk_val = 0; nv_cclk_load = 1;
        tick();
        nv_cclk_load = 0; nv_cclk_val = 1;
        check("R9 nv override", link_status[12], 0);
        tick();
        check("R9 value held", link_status[12], 0);
        // R8 downstream strap
        strap_cclk_ds = 1; strap_cclk_us = 0;
        do_reset(1'b0);
        #1;
        check("R8 strap downstream", link_status[12], 1);

        // R1 / R10 / R11 small sweeps
        for (int r = 0; r < 2; r++) begin
            rate_gen2 = r[0];
            #1;
            check("R1 speed", link_status[3:0], r == 1 ? 2 : 1);
        end
        for (int c = 0; c < 4; c++) begin
            cap_dll_rep = c[0]; dll_active = c[1];
            #1;
            check("R10 link active", link_status[13], c[0] & c[1]);
        end

        // R2 R3 R4 R5 R11 exhaustive combinational sweep
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 64; c++) begin
                for (int n = 0; n < 64; n++) begin
                    ltssm_state = 3'(s); cap_max_width = 6'(c); neg_lanes = 6'(n);
                    #1;
                    if (!(legal(c) && c <= LANES))
                        check("R3 unsupported echo", link_status[9:4], exp_width(s, c, n));
                    else if (s == 3 || s == 4 || s == 5)
                        check("R2 width", link_status[9:4], exp_width(s, c, n));
                    else
                        check("R4 untrained zero", link_status[9:4], exp_width(s, c, n));
                    check("R5 training bit", link_status[11], (s == 2 || s == 4) ? 1 : 0);
                    check("R11 reserved", {link_status[15:14], link_status[10]}, 0);
                end
            end
        end

        // R5 / R6 / R7 downstream retrain
        ltssm_state = 3'd3;
        tick();
        pulse_req();
        check("R7 ds kick", train_kick, 1);
        check("R6 set by request", link_status[11], 1);
        tick();
        check("R7 ds kick single", train_kick, 0);
        check("R6 held before training", link_status[11], 1);
        ltssm_state = 3'd2;
        tick();
        check("R5 in config", link_status[11], 1);
        ltssm_state = 3'd3;
        #1;
        check("R5 cleared on exit", link_status[11], 0);

        // R7 upstream delay
        do_reset(1'b1);
        ltssm_state = 3'd3;
        tick();
        pulse_req();
        check("R7 up kick at 0", train_kick, 0);
        for (int i = 1; i <= DLY + 1; i++) begin
            tick();
            check("R7 up kick timing", train_kick, (i == DLY) ? 1 : 0);
        end
        check("R6 pending until training", link_status[11], 1);
        ltssm_state = 3'd4; tick(); ltssm_state = 3'd3; #1;
        check("R6 cleared after recovery", link_status[11], 0);

        // R7 restart, R6 hold while delay runs in configuration
        pulse_req();
        tick(); tick();
        ltssm_state = 3'd2;
        pulse_req();
        ltssm_state = 3'd3;
        tick();
        check("R6 hold during delay", link_status[11], 1);
        for (int i = 2; i <= DLY + 1; i++) begin
            tick();
            check("R7 restart timing", train_kick, (i == DLY) ? 1 : 0);
        end

        // R12 reset clears pending and counter
        pulse_req();
        do_reset(1'b1);
        #1;
        check("R12 pending cleared", link_status[11], 0);
        for (int i = 0; i < DLY + 2; i++) begin
            tick();
            check("R12 no kick after reset", train_kick, 0);
        end

        if (!done) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            done = 1;
        end
        $finish;
    end
endmodule